// File: doc/BRIEF.md
# Sample-Rate and Frame-Sync Generator

This block takes a source clock and produces two timing signals for a serial data port. The first is a generated bit clock, `gclk_o`, whose rate is set by a programmable divider. The second is a periodic frame-sync pulse, `fs_o`. The pulse width and the frame period are both counted in whole generated-clock periods.

The source is either the system clock or an external clock pin. The external pin is sampled in the system clock domain, and a polarity input picks whether its rising or its falling edges advance the divider.

The clock generator and the frame generator each have an active-low run control, so either one can be held in reset on its own. In resync mode, a rising edge on an external receive frame sync restarts both counters, which realigns the generated clock and the frame to that pulse.

A mode input picks the source of the transmit frame sync. It comes either from this generator or from a one-cycle pulse that follows a data-load event supplied by the surrounding port.

Top module: `srg_fsgen`

## Requirements
- R1: While `rst_n` is low, `gclk_o`, `fs_o` and `tx_fs_o` are all 0.
- R2: With the system clock as source and divider value D, `gclk_o` repeats every D+1 cycles. It is high for floor((D+2)/2) cycles and low for the rest. With D=0 it stays at 1.
- R3: When `cg_run_i` and `fs_run_i` rise together with the system clock as source, `gclk_o` and `fs_o` are both 1 after the next clock edge. A new period and a new frame start at once.
- R4: With width W < period P, `fs_o` is high for (W+1)(D+1) cycles and low for (P-W)(D+1) cycles in each frame. Boundary: D=0, W=255 and P=4095 give 256 high and 3840 low.
- R5: `fs_o` rises only on a cycle in which the generated clock starts a new period.
- R6: With `src_int_i`=0, the divider advances only on sampled edges of `ext_clk_i`. The edge is rising when `ext_fall_i`=0 and falling when it is 1. `gclk_o` rises two system-clock edges after the pin edge that starts a period.
- R7: While `fs_run_i` is 0, `fs_o` stays 0 and `gclk_o` keeps toggling.
- R8: While `cg_run_i` is 0, `gclk_o` is 0 one edge later and stays 0, and `fs_o` does not change.
- R9: With `sync_mode_i`=1, a rising `ext_fs_i` makes `gclk_o` and `fs_o` both 1 two edges later. Both counters restart from that point.
- R10: With `sync_mode_i`=0, pulses on `ext_fs_i` do not move the frame timing.
- R11: With `tx_mode_i`=0, `tx_fs_o` is a copy of `load_evt_i` delayed by one cycle.
- R12: With `tx_mode_i`=1, `tx_fs_o` equals `fs_o`, and `load_evt_i` has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the internal source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_int_i | input | 1 | 1 = system clock is the source, 0 = external pin |
| ext_clk_i | input | 1 | External source clock pin |
| ext_fall_i | input | 1 | 0 = rising edges of the pin count, 1 = falling edges |
| sync_mode_i | input | 1 | 1 = restart on rising `ext_fs_i` |
| ext_fs_i | input | 1 | External receive frame sync |
| cg_run_i | input | 1 | Clock generator run, 0 holds it in reset |
| fs_run_i | input | 1 | Frame generator run, 0 holds it in reset |
| div_i | input | 8 | Divider value D, period D+1 source ticks |
| wid_i | input | 8 | Pulse width value W, W+1 generated periods |
| per_i | input | 12 | Frame period value P, P+1 generated periods |
| tx_mode_i | input | 1 | 1 = transmit sync from generator, 0 = from load event |
| load_evt_i | input | 1 | Data-load event pulse |
| gclk_o | output | 1 | Generated bit clock |
| fs_o | output | 1 | Generated frame sync |
| tx_fs_o | output | 1 | Selected transmit frame sync |

## Verification
The assertions check the following on every cycle:
- the idle levels while either run input is low;
- that a frame-sync rise coincides with a divider wrap;
- that the generated clock holds steady on cycles with no source tick;
- the resync response;
- the load-event path of the transmit sync.

Only the bench scenarios can show the phase lengths for a given divider, the frame high and low lengths including the largest period, and the phase of the output relative to each edge polarity of the external pin. They also show that an ignored external sync leaves the next frame at its natural distance.

// File: rtl/srg_pkg.sv
`timescale 1ns/1ps
package srg_pkg;
  // next count of a modulo counter with terminal value lim
  function automatic int unsigned wrap_inc(int unsigned cur, int unsigned lim);
    return (cur >= lim) ? 0 : cur + 1;
  endfunction

  // cycles of high phase for a divide-by-(div+1) clock
  function automatic int unsigned hi_phase(int unsigned div);
    return (div + 2) / 2;
  endfunction

  // frame position inside the sync pulse
  function automatic logic in_pulse(int unsigned pos, int unsigned wid);
    return pos <= wid;
  endfunction
endpackage

// File: rtl/srg_edge_sync.sv
`timescale 1ns/1ps
module srg_edge_sync #(
  parameter int STAGES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din_i,
  input  logic fall_i,
  output logic edge_o
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-1:0], din_i};
  end

  // chain_q[STAGES-1] is the sampled level, chain_q[STAGES] its previous value
  always_comb begin
    if (fall_i) edge_o = ~chain_q[STAGES-1] & chain_q[STAGES];
    else        edge_o = chain_q[STAGES-1] & ~chain_q[STAGES];
  end
endmodule

// File: rtl/srg_clkdiv.sv
`timescale 1ns/1ps
module srg_clkdiv
  import srg_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             gclk_o,
  output logic             wrap_o
);
  logic [DIV_W-1:0] cnt_q, cnt_nxt;
  logic             hi_nxt;

  always_comb begin
    cnt_nxt = DIV_W'(wrap_inc(32'(cnt_q), 32'(div_i)));
    if (restart_i) cnt_nxt = '0;
    hi_nxt = 32'(cnt_nxt) < hi_phase(32'(div_i));
    wrap_o = run_i & (restart_i | (tick_i & (cnt_q >= div_i)));
  end

  // counter primed to all ones so the first tick after run starts a period
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '1;
      gclk_o <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '1;
      gclk_o <= 1'b0;
    end else if (restart_i | tick_i) begin
      cnt_q  <= cnt_nxt;
      gclk_o <= hi_nxt;
    end
  end
endmodule

// File: rtl/srg_framegen.sv
`timescale 1ns/1ps
module srg_framegen
  import srg_pkg::*;
#(
  parameter int WID_W = 8,
  parameter int PER_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             adv_i,
  input  logic             restart_i,
  input  logic [WID_W-1:0] wid_i,
  input  logic [PER_W-1:0] per_i,
  output logic             fs_o
);
  logic [PER_W-1:0] pos_q, pos_nxt;

  always_comb begin
    pos_nxt = PER_W'(wrap_inc(32'(pos_q), 32'(per_i)));
    if (restart_i) pos_nxt = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '1;
      fs_o  <= 1'b0;
    end else if (!run_i) begin
      pos_q <= '1;
      fs_o  <= 1'b0;
    end else if (adv_i) begin
      pos_q <= pos_nxt;
      fs_o  <= in_pulse(32'(pos_nxt), 32'(wid_i));
    end
  end
endmodule

// File: rtl/srg_fsgen.sv
`timescale 1ns/1ps
module srg_fsgen #(
  parameter int DIV_W       = 8,
  parameter int WID_W       = 8,
  parameter int PER_W       = 12,
  parameter int SYNC_STAGES = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_int_i,
  input  logic             ext_clk_i,
  input  logic             ext_fall_i,
  input  logic             sync_mode_i,
  input  logic             ext_fs_i,
  input  logic             cg_run_i,
  input  logic             fs_run_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [WID_W-1:0] wid_i,
  input  logic [PER_W-1:0] per_i,
  input  logic             tx_mode_i,
  input  logic             load_evt_i,
  output logic             gclk_o,
  output logic             fs_o,
  output logic             tx_fs_o
);
  // named internal events, observed by the bound checker
  logic ck_edge;
  logic fs_edge;
  logic tick;
  logic resync;
  logic div_wrap;
  logic load_q;

  srg_edge_sync #(.STAGES(SYNC_STAGES)) u_ck_sync (
    .clk(clk), .rst_n(rst_n), .din_i(ext_clk_i), .fall_i(ext_fall_i), .edge_o(ck_edge)
  );

  srg_edge_sync #(.STAGES(SYNC_STAGES)) u_fs_sync (
    .clk(clk), .rst_n(rst_n), .din_i(ext_fs_i), .fall_i(1'b0), .edge_o(fs_edge)
  );

  assign tick   = src_int_i | ck_edge;
  assign resync = sync_mode_i & fs_edge;

  srg_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run_i(cg_run_i), .tick_i(tick),
    .restart_i(resync), .div_i(div_i), .gclk_o(gclk_o), .wrap_o(div_wrap)
  );

  srg_framegen #(.WID_W(WID_W), .PER_W(PER_W)) u_frm (
    .clk(clk), .rst_n(rst_n), .run_i(fs_run_i), .adv_i(div_wrap),
    .restart_i(resync), .wid_i(wid_i), .per_i(per_i), .fs_o(fs_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) load_q <= 1'b0;
    else        load_q <= load_evt_i;
  end

  assign tx_fs_o = tx_mode_i ? fs_o : load_q;
endmodule

// File: rtl/srg_fsgen_chk.sv
`timescale 1ns/1ps
module srg_fsgen_chk (
  input logic clk,
  input logic rst_n,
  input logic cg_run_i,
  input logic fs_run_i,
  input logic sync_mode_i,
  input logic tx_mode_i,
  input logic load_evt_i,
  input logic gclk_o,
  input logic fs_o,
  input logic tx_fs_o,
  input logic tick,
  input logic resync,
  input logic fs_edge,
  input logic div_wrap
);
  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |-> !gclk_o && !fs_o && !tx_fs_o);

  p_wrap_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    div_wrap |=> gclk_o);

  p_fs_rise_on_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fs_o) |-> $past(div_wrap));

  p_hold_without_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cg_run_i && !tick && !resync |=> $stable(gclk_o));

  p_fs_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !fs_run_i |=> !fs_o);

  p_gclk_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cg_run_i |=> !gclk_o);

  p_resync_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cg_run_i && fs_run_i && sync_mode_i && fs_edge |=> gclk_o && fs_o);

  p_load_path_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_mode_i && $past(!tx_mode_i) |-> tx_fs_o == $past(load_evt_i));
endmodule

bind srg_fsgen srg_fsgen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cg_run_i(cg_run_i), .fs_run_i(fs_run_i),
  .sync_mode_i(sync_mode_i), .tx_mode_i(tx_mode_i), .load_evt_i(load_evt_i),
  .gclk_o(gclk_o), .fs_o(fs_o), .tx_fs_o(tx_fs_o), .tick(tick),
  .resync(resync), .fs_edge(fs_edge), .div_wrap(div_wrap)
);

// File: tb/sim_srg_fsgen.sv
`timescale 1ns/1ps
module sim_srg_fsgen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic src_int = 1'b1, ext_clk = 1'b0, ext_fall = 1'b0;
  logic sync_mode = 1'b0, ext_fs = 1'b0;
  logic cg_run = 1'b0, fs_run = 1'b0;
  logic [7:0]  div = 8'd0;
  logic [7:0]  wid = 8'd0;
  logic [11:0] per = 12'd0;
  logic tx_mode = 1'b0, load_evt = 1'b0;
  logic gclk, fs, tx_fs;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  srg_fsgen u0 (
    .clk(clk), .rst_n(rst_n), .src_int_i(src_int), .ext_clk_i(ext_clk),
    .ext_fall_i(ext_fall), .sync_mode_i(sync_mode), .ext_fs_i(ext_fs),
    .cg_run_i(cg_run), .fs_run_i(fs_run), .div_i(div), .wid_i(wid), .per_i(per),
    .tx_mode_i(tx_mode), .load_evt_i(load_evt),
    .gclk_o(gclk), .fs_o(fs), .tx_fs_o(tx_fs)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg(input int d, input int w, input int p);
    @(negedge clk);
    cg_run = 1'b0; fs_run = 1'b0; src_int = 1'b1;
    div = 8'(d); wid = 8'(w); per = 12'(p);
    @(negedge clk);
    cg_run = 1'b1; fs_run = 1'b1;
  endtask

  // high and low run lengths (system cycles) of gclk (sel=0) or fs (sel=1)
  task automatic meas(input bit sel, output int hi, output int lo);
    logic prev, cur;
    int guard = 0;
    @(negedge clk);
    cur = sel ? fs : gclk;
    do begin
      @(negedge clk);
      prev = cur; cur = sel ? fs : gclk; guard++;
    end while (!(cur && !prev) && guard < 20000);
    hi = 0; lo = 0;
    while (cur && guard < 20000) begin
      hi++; @(negedge clk); cur = sel ? fs : gclk; guard++;
    end
    while (!cur && guard < 20000) begin
      lo++; @(negedge clk); cur = sel ? fs : gclk; guard++;
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!gclk && !fs && !tx_fs, "R1 outputs in reset", {gclk, fs, tx_fs}, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_startup;
    @(negedge clk);
    cg_run = 1'b0; fs_run = 1'b0; src_int = 1'b1; div = 8'd3; wid = 8'd1; per = 12'd3;
    @(negedge clk);
    chk(!gclk, "R8 gclk idle", gclk, 0);
    cg_run = 1'b1; fs_run = 1'b1;
    @(negedge clk);
    chk(gclk && fs, "R3 R5 first period and frame", {gclk, fs}, 3);
    @(negedge clk);
    chk(gclk, "R3 high phase second cycle", gclk, 1);
    @(negedge clk);
    chk(!gclk, "R3 low phase", gclk, 0);
  endtask

  task automatic t_divide;
    int hi, lo, n_hi;
    cfg(3, 0, 0); meas(1'b0, hi, lo);
    chk(hi == 2 && lo == 2, "R2 D=3 high", hi, 2);
    cfg(4, 0, 0); meas(1'b0, hi, lo);
    chk(hi == 3, "R2 D=4 high", hi, 3);
    chk(lo == 2, "R2 D=4 low", lo, 2);
    cfg(255, 0, 0); meas(1'b0, hi, lo);
    chk(hi == 128 && lo == 128, "R2 D=255 high", hi, 128);
    cfg(0, 0, 0);
    repeat (2) @(negedge clk);
    n_hi = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (gclk) n_hi++;
    end
    chk(n_hi == 20, "R2 D=0 steady high", n_hi, 20);
  endtask

  task automatic t_frame;
    int hi, lo;
    cfg(1, 1, 4); meas(1'b1, hi, lo);
    chk(hi == 4 && lo == 6, "R4 D=1 W=1 P=4 high", hi, 4);
    chk(lo == 6, "R4 D=1 W=1 P=4 low", lo, 6);
    cfg(2, 0, 2); meas(1'b1, hi, lo);
    chk(hi == 3 && lo == 6, "R4 D=2 W=0 P=2 low", lo, 6);
    cfg(0, 255, 4095); meas(1'b1, hi, lo);
    chk(hi == 256, "R4 max period high", hi, 256);
    chk(lo == 3840, "R4 max period low", lo, 3840);
  endtask

  task automatic t_ext(input bit pol, input int exp_phase);
    int rises = 0, bad = 0;
    logic prev = 1'b0, cur;
    @(negedge clk);
    cg_run = 1'b0; fs_run = 1'b0; src_int = 1'b0; ext_fall = pol; div = 8'd1; ext_clk = 1'b0;
    repeat (3) @(negedge clk);
    for (int n = 0; n < 80; n++) begin
      @(negedge clk);
      cur = gclk;
      if (cur && !prev) begin
        rises++;
        if (n % 16 != exp_phase) bad++;
      end
      prev = cur;
      if (n == 0) cg_run = 1'b1;
      ext_clk = 1'(n >> 2);
    end
    chk(rises == 5, "R6 rise count", rises, 5);
    chk(bad == 0, pol ? "R6 falling-edge phase" : "R6 rising-edge phase", bad, 0);
    src_int = 1'b1;
  endtask

  task automatic t_gate;
    int rises = 0, fs_hi = 0, moved = 0;
    logic prev = 1'b0, f0;
    cfg(1, 2, 5);
    repeat (5) @(negedge clk);
    fs_run = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (fs) fs_hi++;
      if (gclk && !prev) rises++;
      prev = gclk;
    end
    chk(fs_hi == 0, "R7 fs held low", fs_hi, 0);
    chk(rises == 20, "R7 gclk still running", rises, 20);
    cfg(1, 2, 5);
    repeat (3) @(negedge clk);
    cg_run = 1'b0;
    @(negedge clk);
    f0 = fs;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (gclk || fs != f0) moved++;
    end
    chk(moved == 0, "R8 clock stopped and frame frozen", moved, 0);
  endtask

  task automatic t_sync(input bit s, input int exp_rise);
    logic prev, cur;
    int first = 0, guard = 0, g12 = 0, g13 = 0, g14 = 1;
    cfg(3, 0, 7);
    sync_mode = s; ext_fs = 1'b0;
    cur = fs;
    do begin
      @(negedge clk); prev = cur; cur = fs; guard++;
    end while (!(cur && !prev) && guard < 1000);
    prev = cur;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      cur = fs;
      if (cur && !prev && first == 0) first = k;
      if (k == 12) g12 = gclk;
      if (k == 13) g13 = gclk;
      if (k == 14) g14 = gclk;
      prev = cur;
      if (k == 10) ext_fs = 1'b1;
      if (k == 11) ext_fs = 1'b0;
    end
    if (s) begin
      chk(first == exp_rise, "R9 frame restarted by external sync", first, exp_rise);
      chk(g12 == 1 && g13 == 1 && g14 == 0, "R9 gclk realigned", {g12[0], g13[0], g14[0]}, 6);
    end else begin
      chk(first == exp_rise, "R10 external sync ignored", first, exp_rise);
    end
    sync_mode = 1'b0;
  endtask

  task automatic t_tx;
    int mism = 0;
    @(negedge clk);
    tx_mode = 1'b0; load_evt = 1'b1;
    @(negedge clk);
    load_evt = 1'b0;
    chk(tx_fs, "R11 load pulse passed", tx_fs, 1);
    @(negedge clk);
    chk(!tx_fs, "R11 pulse one cycle", tx_fs, 0);
    cfg(1, 1, 4);
    tx_mode = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (tx_fs != fs) mism++;
      load_evt = (i % 3 == 0);
    end
    chk(mism == 0, "R12 follows generator", mism, 0);
    fs_run = 1'b0; load_evt = 1'b1;
    @(negedge clk);
    load_evt = 1'b0;
    @(negedge clk);
    chk(!tx_fs, "R12 load event ignored", tx_fs, 0);
    tx_mode = 1'b0;
  endtask

  initial begin
    t_reset();
    t_startup();
    t_divide();
    t_frame();
    t_ext(1'b0, 6);
    t_ext(1'b1, 10);
    t_gate();
    t_sync(1'b0, 32);
    t_sync(1'b1, 12);
    t_tx();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule